// File: doc/BRIEF.md
# Interleaved Four-Bank Block Fill Engine

This block refills one cache block from a main memory made of four word-wide banks that share a one-word return path. A requester presents a block-aligned word address with `req_valid` while `busy` is low. The engine sends one word request to each bank, returns the four words of the block in ascending order, one per beat, each tagged with its offset, and pulses `done` with the last word.

In the default overlapped mode the engine starts bank 0 one cycle after acceptance and the other banks on the cycles that follow. The fixed bank latencies therefore run side by side, and a block arrives in 1 + 15 + 4 = 20 cycles instead of four back-to-back 17-cycle accesses. When `req_serial` is set at acceptance, the engine waits for each word to come back before it starts the next one. This gives the 68-cycle non-overlapped figure for comparison.

A bank is outside the block. It samples `bank_req` on a clock edge and raises its `bank_rvalid` bit, with its word on its slice of `bank_rdata`, exactly `BANK_LAT` edges later for one cycle. The engine relies on that fixed latency and keeps no reorder storage.

Top module: `ilv_fill_engine`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `done`, `out_valid` and every `bank_req` bit are 0.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from the cycle after acceptance up to, but not including, the `done` cycle. `req_valid` while `busy` is 1 is ignored.
- R3: Word i of a block goes to bank i, signalled on `bank_req` bit i. `bank_row` carries `req_addr[ADDR_W-1:2]`, and the two low address bits are ignored. At most one `bank_req` bit is high in any cycle.
- R4: In overlapped mode (`req_serial`=0 at acceptance), `bank_req` is 4'b0001, 4'b0010, 4'b0100 and 4'b1000 on four consecutive cycles. The first of these is the cycle right after acceptance.
- R5: In sequential mode (`req_serial`=1 at acceptance), the request for word i+1 appears in the cycle after word i is delivered. Never more than one word is outstanding.
- R6: Each returned word appears with `out_valid`=1, `out_offset` equal to its word index and `out_data` equal to the word its bank returned. Offsets run 0,1,2,3, and in overlapped mode they arrive on four consecutive cycles.
- R7: `done` is a one-cycle pulse in the same cycle as the word with offset 3. `busy` is 0 in that cycle, so a new request can be accepted on the next edge.
- R8: With `BANK_LAT`=15, the first word is visible 17 cycles after the accepting edge. `done` is visible 20 cycles after it in overlapped mode and 68 cycles after it in sequential mode.
- R9: `req_serial` and `req_addr` are sampled only at acceptance. Changing them, or pulsing `req_valid`, during a fill alters neither the row, the bank order nor the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Fill request |
| req_addr | input | ADDR_W | Block-aligned word address |
| req_serial | input | 1 | 1 selects non-overlapped sequential fill |
| busy | output | 1 | Fill in progress; requests are taken only while low |
| bank_req | output | NUM_BANKS | One-cycle request pulse per bank, bit b for bank b |
| bank_row | output | ADDR_W-2 | Row address shared by all banks |
| bank_rvalid | input | NUM_BANKS | Per-bank return strobe |
| bank_rdata | input | NUM_BANKS*DATA_W | Per-bank return word, bank b at bits b*DATA_W upward |
| out_valid | output | 1 | Returned word valid |
| out_offset | output | 2 | Word offset within the block |
| out_data | output | DATA_W | Returned word |
| done | output | 1 | Pulse with the last word of the block |

## Verification
Fills are run in both modes, and every cycle from acceptance to `done` is compared with the expected issue pattern, delivery beats and `done` position. A slip of one cycle, a bank visited out of order or an overlap in sequential mode therefore shows up at once. Addresses with the two low bits set separate correct row extraction from a design that passes them through. Random `req_valid`, `req_addr` and `req_serial` noise during a fill separates sampling at acceptance from sampling later. Back-to-back requests raised in the `done` cycle test that `busy` drops in time for an immediate restart.

// File: rtl/ilv_fill_pkg.sv
package ilv_fill_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_HOLD,
    ST_DRAIN
  } fill_state_e;

  // Cycles from accepting edge to the done cycle for a given mode.
  function automatic int unsigned fill_cycles(input logic serial,
                                              input int unsigned banks,
                                              input int unsigned lat);
    if (serial) return banks * (lat + 2);
    return lat + 1 + banks;
  endfunction

endpackage

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl
  import ilv_fill_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int IDX_W = $clog2(NUM_BANKS),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  input  logic             req_serial_i,
  input  logic             deliver_evt_i,
  input  logic             last_evt_i,
  output logic             busy_o,
  output logic             serial_o,
  output logic             accept_o,
  output logic             issue_fire_o,
  output logic [IDX_W-1:0] issue_idx_o,
  output logic [CNT_W-1:0] issued_cnt_o
);

  fill_state_e      state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] issued_q;
  logic             serial_q;
  logic             last_issue;

  assign busy_o       = (state_q != ST_IDLE);
  assign accept_o     = req_valid_i && !busy_o;
  assign issue_fire_o = (state_q == ST_ISSUE);
  assign issue_idx_o  = idx_q;
  assign issued_cnt_o = issued_q;
  assign serial_o     = serial_q;
  assign last_issue   = (idx_q == IDX_W'(NUM_BANKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      issued_q <= '0;
      serial_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q  <= ST_ISSUE;
            serial_q <= req_serial_i;
            idx_q    <= '0;
            issued_q <= '0;
          end
        end
        ST_ISSUE: begin
          idx_q    <= idx_q + 1'b1;
          issued_q <= issued_q + 1'b1;
          if (serial_q)        state_q <= ST_HOLD;
          else if (last_issue) state_q <= ST_DRAIN;
        end
        ST_HOLD: begin
          if (last_evt_i)         state_q <= ST_IDLE;
          else if (deliver_evt_i) state_q <= ST_ISSUE;
        end
        ST_DRAIN: begin
          if (last_evt_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: acceptance moves straight into issuing
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (busy_o && issue_fire_o));

endmodule

// File: rtl/ilv_fill_issue.sv
module ilv_fill_issue #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 14,
  localparam int IDX_W    = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept_i,
  input  logic [ROW_W-1:0]     blk_row_i,
  input  logic                 issue_fire_i,
  input  logic [IDX_W-1:0]     issue_idx_i,
  output logic [NUM_BANKS-1:0] bank_req_o,
  output logic [ROW_W-1:0]     bank_row_o
);

  logic [NUM_BANKS-1:0] req_d;
  logic [NUM_BANKS-1:0] req_q;
  logic [ROW_W-1:0]     row_q;

  // word index maps to bank index directly (idx is already modulo bank count)
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_dec
    assign req_d[g] = issue_fire_i && (issue_idx_i == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      row_q <= '0;
    end else begin
      req_q <= req_d;
      if (accept_i) row_q <= blk_row_i;
    end
  end

  assign bank_req_o = req_q;
  assign bank_row_o = row_q;

  // R9: row stays put whenever a bank is being addressed
  a_r9_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_req_o) |-> $stable(bank_row_o));

endmodule

// File: rtl/ilv_fill_collect.sv
module ilv_fill_collect #(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_BANKS),
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        busy_i,
  input  logic                        accept_i,
  input  logic [NUM_BANKS-1:0]        bank_rvalid_i,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata_i,
  output logic                        out_valid_o,
  output logic [IDX_W-1:0]            out_offset_o,
  output logic [DATA_W-1:0]           out_data_o,
  output logic                        done_o,
  output logic                        deliver_evt_o,
  output logic                        last_evt_o,
  output logic [CNT_W-1:0]            delivered_cnt_o
);

  logic [DATA_W-1:0] word_a [NUM_BANKS];
  logic [IDX_W-1:0]  want_q;
  logic [CNT_W-1:0]  got_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_unpack
    assign word_a[g] = bank_rdata_i[g*DATA_W +: DATA_W];
  end

  // fixed bank latency keeps returns in issue order: watch only the next bank
  assign deliver_evt_o   = busy_i && bank_rvalid_i[want_q];
  assign last_evt_o      = deliver_evt_o && (want_q == IDX_W'(NUM_BANKS - 1));
  assign delivered_cnt_o = got_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_q       <= '0;
      got_q        <= '0;
      out_valid_o  <= 1'b0;
      out_offset_o <= '0;
      out_data_o   <= '0;
      done_o       <= 1'b0;
    end else begin
      out_valid_o <= deliver_evt_o;
      done_o      <= last_evt_o;
      if (deliver_evt_o) begin
        out_data_o   <= word_a[want_q];
        out_offset_o <= want_q;
        want_q       <= want_q + 1'b1;
        got_q        <= got_q + 1'b1;
      end
      if (accept_i) begin
        want_q <= '0;
        got_q  <= '0;
      end
    end
  end

  // R6: back-to-back beats carry consecutive offsets
  a_r6_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !done_o) |=>
      (!out_valid_o || out_offset_o == IDX_W'($past(out_offset_o) + 1'b1)));

  // R7: done lasts a single cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

endmodule

// File: rtl/ilv_fill_engine.sv
module ilv_fill_engine
  import ilv_fill_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int NUM_BANKS = 4,
  parameter int BANK_LAT  = 15,
  localparam int IDX_W    = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - IDX_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic                        req_serial,
  output logic                        busy,
  output logic [NUM_BANKS-1:0]        bank_req,
  output logic [ROW_W-1:0]            bank_row,
  input  logic [NUM_BANKS-1:0]        bank_rvalid,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata,
  output logic                        out_valid,
  output logic [IDX_W-1:0]            out_offset,
  output logic [DATA_W-1:0]           out_data,
  output logic                        done
);

  localparam int CNT_W = IDX_W + 1;
  localparam int LAT_W = 16;

  // named internal events
  logic             accept_evt;
  logic             issue_fire;
  logic [IDX_W-1:0] issue_idx;
  logic [CNT_W-1:0] issued_cnt;
  logic [CNT_W-1:0] delivered_cnt;
  logic             deliver_evt;
  logic             last_evt;
  logic             serial_q;
  logic [IDX_W-1:0] unused_low_bits;

  assign unused_low_bits = req_addr[IDX_W-1:0];

  ilv_fill_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid),
    .req_serial_i  (req_serial),
    .deliver_evt_i (deliver_evt),
    .last_evt_i    (last_evt),
    .busy_o        (busy),
    .serial_o      (serial_q),
    .accept_o      (accept_evt),
    .issue_fire_o  (issue_fire),
    .issue_idx_o   (issue_idx),
    .issued_cnt_o  (issued_cnt)
  );

  ilv_fill_issue #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept_evt),
    .blk_row_i    (req_addr[ADDR_W-1:IDX_W]),
    .issue_fire_i (issue_fire),
    .issue_idx_i  (issue_idx),
    .bank_req_o   (bank_req),
    .bank_row_o   (bank_row)
  );

  ilv_fill_collect #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) u_collect (
    .clk             (clk),
    .rst_n           (rst_n),
    .busy_i          (busy),
    .accept_i        (accept_evt),
    .bank_rvalid_i   (bank_rvalid),
    .bank_rdata_i    (bank_rdata),
    .out_valid_o     (out_valid),
    .out_offset_o    (out_offset),
    .out_data_o      (out_data),
    .done_o          (done),
    .deliver_evt_o   (deliver_evt),
    .last_evt_o      (last_evt),
    .delivered_cnt_o (delivered_cnt)
  );

  // cycle counter for the latency check, cleared at acceptance
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lat_cnt <= '0;
    else if (accept_evt) lat_cnt <= '0;
    else if (busy)       lat_cnt <= lat_cnt + 1'b1;
  end

  // R3: one bank addressed at a time
  a_r3_onehot_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req));

  // R4: overlapped mode walks the banks on adjacent cycles
  a_r4_next_bank: assert property (@(posedge clk) disable iff (!rst_n)
    ((|bank_req) && !serial_q && !bank_req[NUM_BANKS-1]) |=>
      (bank_req == ($past(bank_req) << 1)));

  // R5: sequential mode never has two words in flight
  a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (serial_q && (|bank_req)) |-> (issued_cnt == delivered_cnt + 1'b1));

  // R7: done coincides with the final word and busy already low
  a_r7_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_valid && !busy && out_offset == IDX_W'(NUM_BANKS - 1)));

  // R8: fill length matches the mode
  a_r8_fill_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == LAT_W'(fill_cycles(serial_q, NUM_BANKS, BANK_LAT))));

endmodule

// File: tb/ilv_fill_engine_bench.sv
module ilv_fill_engine_bench;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int NB     = 4;
  localparam int LAT    = 15;
  localparam int OFF_W  = 2;
  localparam int ROW_W  = ADDR_W - OFF_W;
  localparam int WDOG   = 150000;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  req_valid = 1'b0;
  logic [ADDR_W-1:0]     req_addr = '0;
  logic                  req_serial = 1'b0;
  logic                  busy;
  logic [NB-1:0]         bank_req;
  logic [ROW_W-1:0]      bank_row;
  logic [NB-1:0]         bank_rvalid;
  logic [NB*DATA_W-1:0]  bank_rdata;
  logic                  out_valid;
  logic [OFF_W-1:0]      out_offset;
  logic [DATA_W-1:0]     out_data;
  logic                  done;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  ilv_fill_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NB), .BANK_LAT(LAT))
  u_ilv_fill_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_serial(req_serial), .busy(busy), .bank_req(bank_req), .bank_row(bank_row),
    .bank_rvalid(bank_rvalid), .bank_rdata(bank_rdata), .out_valid(out_valid),
    .out_offset(out_offset), .out_data(out_data), .done(done)
  );

  // content of bank b at row r
  function automatic logic [DATA_W-1:0] bank_word(input int b, input logic [ROW_W-1:0] r);
    logic [31:0] t;
    t = (32'(r) * 32'h0001_9E37) ^ (32'(b) << 24) ^ 32'h5A5A_0F0F;
    return DATA_W'(t);
  endfunction

  // fixed-latency bank models: response LAT edges after the sampling edge
  logic [NB-1:0]    pv   [LAT];
  logic [ROW_W-1:0] prow [LAT][NB];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) pv[s] <= '0;
    end else begin
      pv[0] <= bank_req;
      for (int b = 0; b < NB; b++) prow[0][b] <= bank_row;
      for (int s = 1; s < LAT; s++) begin
        pv[s]   <= pv[s-1];
        prow[s] <= prow[s-1];
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bank_rvalid[b] = pv[LAT-1][b];
      bank_rdata[b*DATA_W +: DATA_W] = bank_word(b, prow[LAT-1][b]);
    end
  end

  // expected schedule, in cycles after the accepting edge
  function automatic int issue_at(input int i, input bit serial);
    return serial ? (1 + i * (LAT + 2)) : (1 + i);
  endfunction

  function automatic int word_at(input int i, input bit serial);
    return serial ? ((i + 1) * (LAT + 2)) : (LAT + 2 + i);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    if (cyc == WDOG && !finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  task automatic run_fill(input logic [ADDR_W-1:0] addr, input bit serial, input bit noise);
    int c0;
    int d;
    int done_d;
    logic [ROW_W-1:0] row;
    string rtag;
    while (busy) @(negedge clk);
    req_valid  = 1'b1;
    req_addr   = addr;
    req_serial = serial;
    @(negedge clk);
    c0     = cyc;
    row    = addr[ADDR_W-1:OFF_W];
    done_d = word_at(NB - 1, serial);
    rtag   = noise ? "R9" : "R3";
    forever begin
      logic [NB-1:0] e_req;
      bit            e_out;
      int            wi;
      d     = cyc - c0;
      e_req = '0;
      e_out = 0;
      wi    = 0;
      for (int i = 0; i < NB; i++) begin
        if (d == issue_at(i, serial)) e_req = NB'(1) << i;
        if (d == word_at(i, serial)) begin
          e_out = 1;
          wi    = i;
        end
      end
      if (serial) chk(bank_req == e_req, "R5", "bank_req", bank_req, e_req);
      else        chk(bank_req == e_req, "R4", "bank_req", bank_req, e_req);
      if (e_req != 0) chk(bank_row == row, rtag, "bank_row", bank_row, row);
      chk(out_valid == e_out, "R6", "out_valid", out_valid, e_out);
      if (e_out) begin
        chk(out_offset == OFF_W'(wi), "R6", "out_offset", out_offset, wi);
        chk(out_data == bank_word(wi, row), "R6", "out_data", out_data, bank_word(wi, row));
      end
      chk(done == (d == done_d), "R8", "done", done, d == done_d);
      chk(busy == (d < done_d), "R2", "busy", busy, d < done_d);
      if (d == done_d) begin
        chk(out_offset == OFF_W'(NB - 1), "R7", "last offset", out_offset, NB - 1);
        req_valid = 1'b0;
        break;
      end
      if (noise) begin
        req_valid  = 1'($urandom % 2);
        req_addr   = ADDR_W'($urandom);
        req_serial = 1'($urandom % 2);
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !out_valid && bank_req == 0, "R1", "in reset",
        {busy, done, out_valid, bank_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !out_valid && bank_req == 0, "R1", "after reset",
        {busy, done, out_valid, bank_req}, 0);
    repeat (4) begin
      @(negedge clk);
      chk(!busy && bank_req == 0, "R2", "idle without request", {busy, bank_req}, 0);
    end

    // directed corners
    run_fill(16'h0000, 1'b0, 1'b0);   // R4 R8 overlapped timing
    run_fill(16'h0000, 1'b1, 1'b0);   // R5 R8 sequential timing
    run_fill(16'hFFFF, 1'b0, 1'b0);   // R3 low bits ignored
    run_fill(16'h1233, 1'b1, 1'b0);   // R3 low bits ignored, sequential
    run_fill(16'h4AC8, 1'b0, 1'b1);   // R9 noise while busy
    run_fill(16'h0004, 1'b1, 1'b1);   // R9 noise in sequential mode
    run_fill(16'hBEE0, 1'b0, 1'b0);   // R7 restart right after done
    run_fill(16'hBEE4, 1'b1, 1'b0);

    // random fills, some back to back
    for (int n = 0; n < 24; n++) begin
      repeat ($urandom % 3) @(negedge clk);
      run_fill(ADDR_W'($urandom), 1'($urandom % 2), 1'($urandom % 2));
    end

    @(negedge clk);
    chk(!busy && !done && !out_valid, "R7", "idle after last fill",
        {busy, done, out_valid}, 0);
    finished = 1;
    summary();
    $finish;
  end

endmodule